// File: doc/BRIEF.md
# Memory Clock Stop Sequencer

This block orders the steps needed to take the clocks away from an SDRAM controller, and to bring them back, without corrupting the attached memory. When software issues a sleep command, the sequencer first asks the memory to enter self-refresh and waits for confirmation. It then stops the memory-interface clock through a request/acknowledge exchange with an external power controller, and after that stops the module clock through a second exchange of the same kind. The gating cells and the clock source sit outside the block and are driven by that power controller.

Some memories need their interface clock to keep running. A configuration input covers this case. It is sampled when the sleep command is accepted. When it is set, the memory-clock exchange is left out of both the stop sequence and the following wake sequence. A wake command runs the steps in the opposite order: module clock, then memory clock, then a fixed settle interval, and finally the self-refresh request is released.

Every acknowledge wait has a timeout. If it expires, the block raises an error flag, drops all of its requests and returns to the awake idle state.

Top module: `memclk_stop_seq`

## Requirements
- R1: While reset is asserted, and on the first cycle after reset, sr_req, mem_req, mod_req, busy, asleep and err are all 0.
- R2: A sleep_cmd seen in the awake idle state (busy=0, asleep=0) sets sr_req and busy at the next clock edge. Neither clock request rises before sr_ack has been seen at 1.
- R3: Each clock exchange is four-phase. The request stays at 1 until its acknowledge is seen at 1, then drops. The next step begins only after that acknowledge is seen at 0. When stopping, the whole memory-clock exchange comes before the module-clock exchange, and the two requests are never at 1 together.
- R4: cont_clk_cfg is sampled when the sleep command is accepted. If it was 1, mem_req stays 0 for the rest of that stop sequence and for the wake sequence that follows, whatever the input does in between.
- R5: When the stop sequence ends, busy falls and asleep rises on the same edge, and sr_req stays at 1 while asleep.
- R6: A wake_cmd seen while asleep (and not busy) clears asleep and raises busy. The module-clock exchange runs first, then the memory-clock exchange (unless it is skipped). After SETTLE_CYC further cycles, sr_req and busy fall together.
- R7: The block ignores sleep_cmd and wake_cmd while busy, ignores sleep_cmd while asleep, and ignores wake_cmd while awake. An ignored command leaves every output unchanged.
- R8: Each acknowledge wait allows TIMEOUT_CYC cycles, and an acknowledge seen on the last of them is accepted. If the wait is not met by then, err rises on the next edge and, on that same edge, sr_req, mem_req, mod_req, busy and asleep all go to 0.
- R9: Once set, err stays at 1 until the next accepted sleep or wake command, which clears it on the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_cmd | input | 1 | Software request to stop the clocks |
| wake_cmd | input | 1 | Software request to restore the clocks |
| cont_clk_cfg | input | 1 | 1 = memory needs its interface clock running continuously |
| sr_req | output | 1 | Self-refresh request to the SDRAM controller |
| sr_ack | input | 1 | Self-refresh confirmation |
| mem_req | output | 1 | Memory-interface clock handshake request |
| mem_ack | input | 1 | Memory-interface clock handshake acknowledge |
| mod_req | output | 1 | Module clock handshake request |
| mod_ack | input | 1 | Module clock handshake acknowledge |
| busy | output | 1 | A sequence is in progress |
| asleep | output | 1 | Clocks are stopped and memory is in self-refresh |
| err | output | 1 | An acknowledge wait timed out |

## Verification
Two events can land on the same clock edge: an acknowledge arriving, and the timeout of the wait for that acknowledge expiring. The bench sets the memory acknowledge delay exactly equal to the timeout, so the acknowledge first becomes visible on the last allowed cycle. It then withholds the acknowledge completely in a second run. The first run must finish the sequence with no error, and the second must abort with err set. Holding sleep_cmd high across the edge where a wake sequence completes is a second collision of the same kind. There the command must be ignored on the completing edge and accepted one edge later. In every case a behavioural step-queue model makes the call, compared against the outputs on every cycle.

// File: rtl/memclk_seq_pkg.sv
package memclk_seq_pkg;

    typedef enum logic [3:0] {
        ST_AWAKE,
        ST_SR_ON,
        ST_MEM_STOP_HI,
        ST_MEM_STOP_LO,
        ST_MOD_STOP_HI,
        ST_MOD_STOP_LO,
        ST_ASLEEP,
        ST_MOD_RUN_HI,
        ST_MOD_RUN_LO,
        ST_MEM_RUN_HI,
        ST_MEM_RUN_LO,
        ST_SETTLE
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
        logic       sr_en;
        logic       mem_req;
        logic       mod_req;
        logic       busy;
        logic       asleep;
        logic       err;
        logic       skip_mem;
    } seq_regs_t;

    localparam seq_regs_t SEQ_REGS_RST = '{
        state:    ST_AWAKE,
        sr_en:    1'b0,
        mem_req:  1'b0,
        mod_req:  1'b0,
        busy:     1'b0,
        asleep:   1'b0,
        err:      1'b0,
        skip_mem: 1'b0
    };

endpackage

// File: rtl/memclk_seq_timer.sv
module memclk_seq_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    output logic expired
);
    localparam int W = $clog2(LIMIT + 1);
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (restart) begin
            cnt_d = '0;
        end else if (run && cnt_q != LAST) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = run && (cnt_q == LAST);

endmodule

// File: rtl/memclk_stop_seq.sv
module memclk_stop_seq
    import memclk_seq_pkg::*;
#(
    parameter int TIMEOUT_CYC = 64,
    parameter int SETTLE_CYC  = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_cmd,
    input  logic wake_cmd,
    input  logic cont_clk_cfg,
    output logic sr_req,
    input  logic sr_ack,
    output logic mem_req,
    input  logic mem_ack,
    output logic mod_req,
    input  logic mod_ack,
    output logic busy,
    output logic asleep,
    output logic err
);

    seq_regs_t r_d, r_q;
    logic      in_wait;
    logic      restart;
    logic      to_expired;
    logic      settle_done;

    // Any state that waits on an acknowledge level is guarded by the timeout.
    assign in_wait = (r_q.state != ST_AWAKE) && (r_q.state != ST_ASLEEP)
                  && (r_q.state != ST_SETTLE);
    assign restart = (r_d.state != r_q.state);

    memclk_seq_timer #(.LIMIT(TIMEOUT_CYC)) i_ack_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .run     (in_wait),
        .expired (to_expired)
    );

    memclk_seq_timer #(.LIMIT(SETTLE_CYC)) i_settle_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .run     (r_q.state == ST_SETTLE),
        .expired (settle_done)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_AWAKE: begin
                if (sleep_cmd) begin
                    r_d.state    = ST_SR_ON;
                    r_d.sr_en    = 1'b1;
                    r_d.busy     = 1'b1;
                    r_d.err      = 1'b0;
                    r_d.skip_mem = cont_clk_cfg;
                end
            end
            ST_SR_ON: begin
                if (sr_ack) begin
                    if (r_q.skip_mem) begin
                        r_d.state   = ST_MOD_STOP_HI;
                        r_d.mod_req = 1'b1;
                    end else begin
                        r_d.state   = ST_MEM_STOP_HI;
                        r_d.mem_req = 1'b1;
                    end
                end
            end
            ST_MEM_STOP_HI: begin
                if (mem_ack) begin
                    r_d.state   = ST_MEM_STOP_LO;
                    r_d.mem_req = 1'b0;
                end
            end
            ST_MEM_STOP_LO: begin
                if (!mem_ack) begin
                    r_d.state   = ST_MOD_STOP_HI;
                    r_d.mod_req = 1'b1;
                end
            end
            ST_MOD_STOP_HI: begin
                if (mod_ack) begin
                    r_d.state   = ST_MOD_STOP_LO;
                    r_d.mod_req = 1'b0;
                end
            end
            ST_MOD_STOP_LO: begin
                if (!mod_ack) begin
                    r_d.state  = ST_ASLEEP;
                    r_d.busy   = 1'b0;
                    r_d.asleep = 1'b1;
                end
            end
            ST_ASLEEP: begin
                if (wake_cmd) begin
                    r_d.state   = ST_MOD_RUN_HI;
                    r_d.mod_req = 1'b1;
                    r_d.busy    = 1'b1;
                    r_d.asleep  = 1'b0;
                    r_d.err     = 1'b0;
                end
            end
            ST_MOD_RUN_HI: begin
                if (mod_ack) begin
                    r_d.state   = ST_MOD_RUN_LO;
                    r_d.mod_req = 1'b0;
                end
            end
            ST_MOD_RUN_LO: begin
                if (!mod_ack) begin
                    if (r_q.skip_mem) begin
                        r_d.state   = ST_SETTLE;
                    end else begin
                        r_d.state   = ST_MEM_RUN_HI;
                        r_d.mem_req = 1'b1;
                    end
                end
            end
            ST_MEM_RUN_HI: begin
                if (mem_ack) begin
                    r_d.state   = ST_MEM_RUN_LO;
                    r_d.mem_req = 1'b0;
                end
            end
            ST_MEM_RUN_LO: begin
                if (!mem_ack) begin
                    r_d.state = ST_SETTLE;
                end
            end
            ST_SETTLE: begin
                if (settle_done) begin
                    r_d.state = ST_AWAKE;
                    r_d.sr_en = 1'b0;
                    r_d.busy  = 1'b0;
                end
            end
            default: r_d = SEQ_REGS_RST;
        endcase

        // A wait that is still unmet on its last allowed cycle aborts the sequence.
        if (in_wait && (r_d.state == r_q.state) && to_expired) begin
            r_d     = SEQ_REGS_RST;
            r_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= SEQ_REGS_RST;
        end else begin
            r_q <= r_d;
        end
    end

    assign sr_req  = r_q.sr_en;
    assign mem_req = r_q.mem_req;
    assign mod_req = r_q.mod_req;
    assign busy    = r_q.busy;
    assign asleep  = r_q.asleep;
    assign err     = r_q.err;

endmodule

// File: rtl/memclk_stop_seq_chk.sv
module memclk_stop_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic sleep_cmd,
    input logic wake_cmd,
    input logic cont_clk_cfg,
    input logic sr_req,
    input logic mem_req,
    input logic mem_ack,
    input logic mod_req,
    input logic busy,
    input logic asleep,
    input logic err
);

    logic cont_seen_q;
    logic sleep_taken;
    logic wake_taken;

    assign sleep_taken = sleep_cmd && !busy && !asleep;
    assign wake_taken  = wake_cmd && asleep && !busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cont_seen_q <= 1'b0;
        end else if (sleep_taken) begin
            cont_seen_q <= cont_clk_cfg;
        end
    end

    AST_CLK_REQ_NEEDS_SR: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req || mod_req) |-> sr_req);                                   // R2

    AST_ONE_CLK_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req && mod_req));                                             // R3

    AST_MEM_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req || err));                        // R3

    AST_CONT_CLK_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (cont_seen_q && (busy || asleep)) |-> !mem_req);                    // R4

    AST_ASLEEP_IN_SR: assert property (@(posedge clk) disable iff (!rst_n)
        asleep |-> (sr_req && !busy));                                      // R5

    AST_WAKE_WHILE_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !asleep && wake_cmd && !sleep_cmd) |=> !busy);            // R7

    AST_ABORT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> (!busy && !asleep && !sr_req && !mem_req && !mod_req)); // R8

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !sleep_taken && !wake_taken) |=> err);                      // R9

endmodule

bind memclk_stop_seq memclk_stop_seq_chk i_chk (.*);

// File: tb/test_memclk_stop_seq.sv
`timescale 1ns/1ps
module test_memclk_stop_seq;

    localparam int TO = 12;
    localparam int ST = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sleep_cmd = 1'b0, wake_cmd = 1'b0, cont_cfg = 1'b0;
    logic sr_ack = 1'b0, mem_ack = 1'b0, mod_ack = 1'b0;
    logic sr_req, mem_req, mod_req, busy, asleep, err;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    memclk_stop_seq #(.TIMEOUT_CYC(TO), .SETTLE_CYC(ST)) i_memclk_stop_seq (
        .clk(clk), .rst_n(rst_n), .sleep_cmd(sleep_cmd), .wake_cmd(wake_cmd),
        .cont_clk_cfg(cont_cfg), .sr_req(sr_req), .sr_ack(sr_ack),
        .mem_req(mem_req), .mem_ack(mem_ack), .mod_req(mod_req), .mod_ack(mod_ack),
        .busy(busy), .asleep(asleep), .err(err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $time, act, exp);
        end
    endtask

    // Power-controller and memory responders: ack follows req after a delay.
    int  d_sr = 1, d_mem = 2, d_mod = 3;
    bit  h_sr = 0, h_mem = 0, h_mod = 0;
    int  c_sr = 0, c_mem = 0, c_mod = 0;
    bit  mem_seen = 0;

    always @(negedge clk) begin
        if (!rst_n) begin
            sr_ack = 0; mem_ack = 0; mod_ack = 0; c_sr = 0; c_mem = 0; c_mod = 0;
        end else begin
            if (sr_req != sr_ack && !h_sr) begin
                c_sr++; if (c_sr >= d_sr) begin sr_ack = sr_req; c_sr = 0; end
            end else c_sr = 0;
            if (mem_req != mem_ack && !h_mem) begin
                c_mem++; if (c_mem >= d_mem) begin mem_ack = mem_req; c_mem = 0; end
            end else c_mem = 0;
            if (mod_req != mod_ack && !h_mod) begin
                c_mod++; if (c_mod >= d_mod) begin mod_ack = mod_req; c_mod = 0; end
            end else c_mod = 0;
        end
    end

    always @(posedge clk) if (mem_req) mem_seen = 1;

    // Reference model: a queue of (line, level) steps; line 3 is the settle wait.
    typedef struct { int line; bit lvl; } step_t;
    step_t q[$];
    bit e_sr, e_mem, e_mod, e_busy, e_asleep, e_err, m_skip, m_down;
    int wcnt;

    function automatic bit ack_of(input int line);
        case (line)
            0: return sr_ack;
            1: return mem_ack;
            default: return mod_ack;
        endcase
    endfunction

    function automatic void drive(input step_t s);
        case (s.line)
            0: e_sr = s.lvl;
            1: e_mem = s.lvl;
            2: e_mod = s.lvl;
            default: ;
        endcase
    endfunction

    function automatic step_t mk(input int line, input bit lvl);
        step_t s; s.line = line; s.lvl = lvl; return s;
    endfunction

    function automatic void finish_seq();
        e_busy = 0;
        if (m_down) e_asleep = 1; else e_sr = 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            e_sr = 0; e_mem = 0; e_mod = 0; e_busy = 0; e_asleep = 0; e_err = 0;
            m_skip = 0; m_down = 0; wcnt = 0; q.delete();
        end else if (!e_busy) begin
            if (!e_asleep && sleep_cmd) begin
                m_skip = cont_cfg; m_down = 1; e_err = 0; e_busy = 1; q.delete();
                q.push_back(mk(0, 1));
                if (!m_skip) begin q.push_back(mk(1, 1)); q.push_back(mk(1, 0)); end
                q.push_back(mk(2, 1)); q.push_back(mk(2, 0));
                drive(q[0]); wcnt = 0;
            end else if (e_asleep && wake_cmd) begin
                m_down = 0; e_err = 0; e_busy = 1; e_asleep = 0; q.delete();
                q.push_back(mk(2, 1)); q.push_back(mk(2, 0));
                if (!m_skip) begin q.push_back(mk(1, 1)); q.push_back(mk(1, 0)); end
                q.push_back(mk(3, 0));
                drive(q[0]); wcnt = 0;
            end
        end else if (q[0].line == 3) begin
            if (wcnt == ST - 1) begin void'(q.pop_front()); finish_seq(); end
            else wcnt++;
        end else if (ack_of(q[0].line) == q[0].lvl) begin
            void'(q.pop_front()); wcnt = 0;
            if (q.size() > 0) drive(q[0]); else finish_seq();
        end else if (wcnt == TO - 1) begin
            e_sr = 0; e_mem = 0; e_mod = 0; e_busy = 0; e_asleep = 0; e_err = 1;
            q.delete();
        end else begin
            wcnt++;
        end
    end

    // Cycle-by-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(sr_req == e_sr,     "R2 sr_req",  sr_req,  e_sr);
            chk(mem_req == e_mem,   "R3 mem_req", mem_req, e_mem);
            chk(mod_req == e_mod,   "R3 mod_req", mod_req, e_mod);
            chk(busy == e_busy,     "R7 busy",    busy,    e_busy);
            chk(asleep == e_asleep, "R5 asleep",  asleep,  e_asleep);
            chk(err == e_err,       "R8 err",     err,     e_err);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_sleep();
        @(negedge clk) sleep_cmd = 1; @(negedge clk) sleep_cmd = 0;
    endtask

    task automatic pulse_wake();
        @(negedge clk) wake_cmd = 1; @(negedge clk) wake_cmd = 0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 400 && busy; i++) @(negedge clk);
    endtask

    task automatic summary();
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        n_checks++; n_errors++;
        $display("FAIL R7 watchdog: actual=running expected=finished");
        summary();
    end

    initial begin
        cyc(2);
        chk({sr_req, mem_req, mod_req, busy, asleep, err} == 6'b0, "R1 in reset",
            {sr_req, mem_req, mod_req, busy, asleep, err}, 0);
        rst_n = 1;
        cyc(1);
        chk({sr_req, mem_req, mod_req, busy, asleep, err} == 6'b0, "R1 after reset",
            {sr_req, mem_req, mod_req, busy, asleep, err}, 0);

        // Normal stop then wake, memory clock included.
        mem_seen = 0;
        pulse_sleep();
        chk(busy && sr_req && !mem_req && !mod_req, "R2 sleep accepted",
            {busy, sr_req, mem_req, mod_req}, 4'b1100);
        wait_idle();
        chk(asleep && sr_req, "R5 asleep holds self-refresh", {asleep, sr_req}, 2'b11);
        chk(mem_seen, "R3 memory clock handshake ran", mem_seen, 1);
        pulse_wake();
        wait_idle();
        chk(!asleep && !sr_req && !err, "R6 wake releases self-refresh",
            {asleep, sr_req, err}, 0);

        // Ignored commands.
        pulse_wake();
        chk(!busy && !asleep, "R7 wake while awake ignored", {busy, asleep}, 0);
        @(negedge clk) sleep_cmd = 1;
        @(negedge clk) wake_cmd = 1;
        cyc(6);
        sleep_cmd = 0; wake_cmd = 0;
        wait_idle();
        chk(asleep && !busy, "R7 commands while busy ignored", {asleep, busy}, 2'b10);
        pulse_sleep();
        chk(asleep && !busy, "R7 sleep while asleep ignored", {asleep, busy}, 2'b10);

        // Sleep held across the edge where a wake sequence completes.
        @(negedge clk) wake_cmd = 1;
        @(negedge clk) wake_cmd = 0; sleep_cmd = 1;
        wait_idle();
        chk(!busy && !asleep, "R7 command at completing edge ignored", {busy, asleep}, 0);
        cyc(1);
        sleep_cmd = 0;
        chk(busy == 1, "R7 command accepted after completion", busy, 1);
        wait_idle();
        pulse_wake();
        wait_idle();

        // Continuous clock: memory handshake skipped both ways.
        cont_cfg = 1; mem_seen = 0;
        pulse_sleep();
        cont_cfg = 0;
        wait_idle();
        chk(asleep, "R4 stop completes without memory clock", asleep, 1);
        pulse_wake();
        wait_idle();
        chk(!mem_seen, "R4 mem_req never asserted", mem_seen, 0);

        // Acknowledge on the last allowed cycle.
        d_mem = TO;
        pulse_sleep();
        wait_idle();
        chk(!err && asleep, "R8 ack on last cycle accepted", {err, asleep}, 2'b01);
        pulse_wake();
        wait_idle();
        d_mem = 2;

        // Acknowledge withheld: timeout.
        h_mem = 1;
        pulse_sleep();
        wait_idle();
        chk(err && !sr_req && !asleep && !mem_req, "R8 timeout aborts",
            {err, sr_req, asleep, mem_req}, 4'b1000);
        h_mem = 0;
        cyc(4);
        chk(err, "R9 err held while idle", err, 1);
        pulse_sleep();
        chk(!err && busy, "R9 err cleared by accepted sleep", {err, busy}, 2'b01);
        wait_idle();
        pulse_wake();
        wait_idle();
        chk(!busy && !asleep && !err, "R6 final wake", {busy, asleep, err}, 0);

        cyc(2);
        summary();
    end

endmodule